// File: doc/BRIEF.md
# Reference Clock Divider with Tri-Level Ratio Select

This block divides a reference clock by a whole-number ratio and emits a one-cycle tick at the divided rate. The tick drives a phase comparator and a frequency monitor. The ratio is one of nine values. Two select inputs choose it. Each select reports one of three pin states (tied low, tied high or left floating) as a 2-bit code that was decoded upstream.

A runtime plus-one input raises the chosen ratio N to N+1. Moving the divided rate this way shifts unwanted harmonics away from a band of interest. For example, 16.384 MHz divided by 32, 17.920 MHz by 35, 18.432 MHz by 36, 24.576 MHz by 48 and 32.768 MHz by 64 each give 512 kHz. The block samples the selects and the plus-one input only at a terminal count. A change therefore never cuts short the period already in progress.

Top module: `refdiv_top`

## Requirements
- R1: With the first select low (code 2'b00), the second select low (2'b00) gives a ratio of 48, high (2'b01) gives 33 and floating (2'b10) gives 36.
- R2: With the first select floating (2'b10), the second select low gives 64, high gives 63 and floating gives 65.
- R3: With the first select high (2'b01), the second select low gives 49, high gives 32 and floating gives 35.
- R4: On either select, the code 2'b11 acts exactly like floating (2'b10).
- R5: While the plus-one input is high at the terminal count, the following period lasts the decoded ratio plus one clocks.
- R6: The tick is high for exactly one clock per period, and there is one tick per period.
- R7: While reset is held, the tick is low. The first tick appears at the Nth rising clock edge after reset is released, where N is the ratio selected during the last reset cycle.
- R8: A change of either select or of the plus-one input in the middle of a period leaves that period unchanged. The inputs sampled at the edge that raises the tick set the length of the next period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Reference clock to be divided |
| rst | input | 1 | Synchronous reset, active high |
| sel_a_i | input | 2 | First tri-level select code (00 low, 01 high, 10/11 floating) |
| sel_b_i | input | 2 | Second tri-level select code (same encoding) |
| plus_one_i | input | 1 | Lengthens the next period by one clock |
| tick_o | output | 1 | One-cycle pulse per divided period |

## Verification
The bench builds the block with its default counter width, which the package derives from the largest ratio (66). At this width all nine ratios and their plus-one variants run to many complete periods in a short run. Directed runs measure the first-tick latency and the steady period for all nine select pairs, the 2'b11 aliases and the plus-one case. They also move the selects mid-period to expose how the ratio is latched. A random phase then changes the selects and the plus-one input at arbitrary cycles, and a behavioural model checks the tick against the expected edge on every clock.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;

    typedef enum logic [1:0] {
        LVL_LOW   = 2'b00,
        LVL_HIGH  = 2'b01,
        LVL_FLOAT = 2'b10
    } lvl_e;

    localparam int unsigned FACTOR_MIN      = 32;
    localparam int unsigned FACTOR_BASE_MAX = 65;
    localparam int unsigned FACTOR_MAX      = FACTOR_BASE_MAX + 1;
    localparam int unsigned CNT_W           = $clog2(FACTOR_MAX + 1);

    typedef logic [CNT_W-1:0] ratio_t;

    typedef struct packed {
        lvl_e first;
        lvl_e second;
    } sel_pair_t;

    // Raw code to level; the unused code 2'b11 folds onto floating.
    function automatic lvl_e norm_level(input logic [1:0] code);
        case (code)
            2'b00:   return LVL_LOW;
            2'b01:   return LVL_HIGH;
            default: return LVL_FLOAT;
        endcase
    endfunction

    function automatic ratio_t base_ratio(input sel_pair_t s);
        ratio_t r;
        unique case (s.first)
            LVL_LOW: begin
                case (s.second)
                    LVL_LOW:  r = ratio_t'(48);
                    LVL_HIGH: r = ratio_t'(33);
                    default:  r = ratio_t'(36);
                endcase
            end
            LVL_HIGH: begin
                case (s.second)
                    LVL_LOW:  r = ratio_t'(49);
                    LVL_HIGH: r = ratio_t'(32);
                    default:  r = ratio_t'(35);
                endcase
            end
            default: begin
                case (s.second)
                    LVL_LOW:  r = ratio_t'(64);
                    LVL_HIGH: r = ratio_t'(63);
                    default:  r = ratio_t'(65);
                endcase
            end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/refdiv_decode.sv
module refdiv_decode
    import refdiv_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic [1:0]   sel_a_i,
    input  logic [1:0]   sel_b_i,
    output logic [W-1:0] ratio_o
);

    localparam int NUM_SEL = 2;

    logic [1:0] raw   [NUM_SEL];
    lvl_e       level [NUM_SEL];
    sel_pair_t  pair;

    assign raw[0] = sel_a_i;
    assign raw[1] = sel_b_i;

    // Each select input gets its own level normaliser.
    for (genvar g = 0; g < NUM_SEL; g++) begin : g_norm
        assign level[g] = norm_level(raw[g]);
    end

    always_comb begin
        pair.first  = level[0];
        pair.second = level[1];
        ratio_o     = W'(base_ratio(pair));
    end

endmodule

// File: rtl/refdiv_counter.sv
module refdiv_counter #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] ratio_i,
    output logic         tick_o,
    output logic [W-1:0] period_o
);

    logic [W-1:0] cnt_q;
    logic [W-1:0] period_q;
    logic         tick_q;
    logic         terminal;

    assign terminal = (cnt_q == period_q - W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            period_q <= ratio_i;
            tick_q   <= 1'b0;
        end else if (terminal) begin
            cnt_q    <= '0;
            period_q <= ratio_i;
            tick_q   <= 1'b1;
        end else begin
            cnt_q    <= cnt_q + W'(1);
            tick_q   <= 1'b0;
        end
    end

    assign tick_o   = tick_q;
    assign period_o = period_q;

endmodule

// File: rtl/refdiv_top.sv
module refdiv_top
    import refdiv_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic       clk_ref,
    input  logic       rst,
    input  logic [1:0] sel_a_i,
    input  logic [1:0] sel_b_i,
    input  logic       plus_one_i,
    output logic       tick_o
);

    logic [W-1:0] base_ratio_w;
    logic [W-1:0] next_ratio;
    logic [W-1:0] active_period;

    refdiv_decode #(.W(W)) u_decode (
        .sel_a_i (sel_a_i),
        .sel_b_i (sel_b_i),
        .ratio_o (base_ratio_w)
    );

    assign next_ratio = base_ratio_w + W'(plus_one_i);

    refdiv_counter #(.W(W)) u_counter (
        .clk      (clk_ref),
        .rst      (rst),
        .ratio_i  (next_ratio),
        .tick_o   (tick_o),
        .period_o (active_period)
    );

endmodule

// File: rtl/refdiv_checker.sv
module refdiv_checker
    import refdiv_pkg::*;
#(
    parameter int W = CNT_W
) (
    input logic         clk,
    input logic         rst,
    input logic         tick,
    input logic [W-1:0] base_ratio,
    input logic [W-1:0] active_period
);

    localparam logic [W:0]   GAP_LO = (W+1)'(FACTOR_MIN - 1);
    localparam logic [W:0]   GAP_HI = (W+1)'(FACTOR_MAX);
    localparam logic [W-1:0] PER_LO = W'(FACTOR_MIN);
    localparam logic [W-1:0] PER_HI = W'(FACTOR_MAX);

    logic       armed_q;
    logic       rst_d_q;
    logic [W:0] gap_q;

    always_ff @(posedge clk) begin
        rst_d_q <= rst;
        if (rst) begin
            armed_q <= 1'b0;
            gap_q   <= '0;
        end else begin
            armed_q <= 1'b1;
            if (tick)
                gap_q <= '0;
            else if (gap_q != '1)
                gap_q <= gap_q + (W+1)'(1);
        end
    end

    // R7: tick stays low while reset has been held
    p_quiet_in_reset_r7: assert property (@(posedge clk)
        rst_d_q |-> !tick);

    // R6: one-cycle pulse
    p_single_cycle_r6: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

    // R5: spacing of ticks within the ratio range including plus-one
    p_gap_bounds_r5: assert property (@(posedge clk) disable iff (rst)
        tick |-> (gap_q >= GAP_LO && gap_q <= GAP_HI));

    // R1: decoder output is one of the nine ratios
    p_legal_ratio_r1: assert property (@(posedge clk) disable iff (rst)
        base_ratio inside {W'(32), W'(33), W'(35), W'(36), W'(48),
                           W'(49), W'(63), W'(64), W'(65)});

    // R8: latched period only moves together with a tick
    p_period_update_r8: assert property (@(posedge clk) disable iff (rst || !armed_q)
        !$stable(active_period) |-> tick);

    // R5: latched period never exceeds the largest ratio plus one
    p_period_range_r5: assert property (@(posedge clk) disable iff (rst)
        active_period >= PER_LO && active_period <= PER_HI);

endmodule

bind refdiv_top refdiv_checker #(.W(W)) u_chk (
    .clk           (clk_ref),
    .rst           (rst),
    .tick          (tick_o),
    .base_ratio    (base_ratio_w),
    .active_period (active_period)
);

// File: tb/refdiv_top_bench.sv
module refdiv_top_bench;

    logic       clk_ref = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] sel_a_i = 2'b00;
    logic [1:0] sel_b_i = 2'b00;
    logic       plus_one_i = 1'b0;
    logic       tick_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk_ref = ~clk_ref;   // 125 MHz

    refdiv_top u_refdiv_top (
        .clk_ref    (clk_ref),
        .rst        (rst),
        .sel_a_i    (sel_a_i),
        .sel_b_i    (sel_b_i),
        .plus_one_i (plus_one_i),
        .tick_o     (tick_o)
    );

    // Ratio table from R1-R3, with R4 aliasing and R5 plus-one.
    function automatic int expect_ratio(input logic [1:0] a, input logic [1:0] b, input logic p);
        int ia, ib, r;
        ia = (a == 2'b11) ? 2 : int'(a);
        ib = (b == 2'b11) ? 2 : int'(b);
        r  = 0;
        if (ia == 0) r = (ib == 0) ? 48 : (ib == 1) ? 33 : 36;
        if (ia == 1) r = (ib == 0) ? 49 : (ib == 1) ? 32 : 35;
        if (ia == 2) r = (ib == 0) ? 64 : (ib == 1) ? 63 : 65;
        return r + (p ? 1 : 0);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Behavioural model: absolute edge index of the next expected tick.
    int  edge_idx  = 0;
    int  next_edge = 0;
    bit  exp_tick  = 1'b0;
    bit  model_on  = 1'b0;

    always @(posedge clk_ref) begin
        if (rst) begin
            edge_idx  = 0;
            next_edge = expect_ratio(sel_a_i, sel_b_i, plus_one_i);
            exp_tick  = 1'b0;
        end else begin
            edge_idx++;
            exp_tick = (edge_idx == next_edge);
            if (exp_tick)
                next_edge = edge_idx + expect_ratio(sel_a_i, sel_b_i, plus_one_i);
        end
        model_on = 1'b1;
    end

    always @(negedge clk_ref) begin
        if (model_on && !done)
            check(tick_o === exp_tick, "R6 per-cycle model", int'(tick_o), int'(exp_tick));
    end

    task automatic apply_reset(input logic [1:0] a, input logic [1:0] b, input logic p);
        @(negedge clk_ref);
        rst = 1'b1; sel_a_i = a; sel_b_i = b; plus_one_i = p;
        repeat (3) @(negedge clk_ref);
        check(tick_o === 1'b0, "R7 low in reset", int'(tick_o), 0);
        rst = 1'b0;
    endtask

    // Counts negedges until tick is seen high.
    task automatic wait_tick(output int n);
        n = 0;
        do begin
            @(negedge clk_ref);
            n++;
        end while (tick_o !== 1'b1 && n < 500);
    endtask

    task automatic run_pair(input logic [1:0] a, input logic [1:0] b, input logic p,
                            input int exp, input string req);
        int n;
        apply_reset(a, b, p);
        wait_tick(n);
        check(n == exp, {req, " first tick"}, n, exp);
        wait_tick(n);
        check(n == exp, {req, " period"}, n, exp);
        @(negedge clk_ref);
        check(tick_o === 1'b0, "R6 width", int'(tick_o), 0);
    endtask

    initial begin
        int n;
        check(1'b1, "R7 start", 0, 0);
        // R1
        run_pair(2'b00, 2'b00, 1'b0, 48, "R1 low/low");
        run_pair(2'b00, 2'b01, 1'b0, 33, "R1 low/high");
        run_pair(2'b00, 2'b10, 1'b0, 36, "R1 low/float");
        // R2
        run_pair(2'b10, 2'b00, 1'b0, 64, "R2 float/low");
        run_pair(2'b10, 2'b01, 1'b0, 63, "R2 float/high");
        run_pair(2'b10, 2'b10, 1'b0, 65, "R2 float/float");
        // R3
        run_pair(2'b01, 2'b00, 1'b0, 49, "R3 high/low");
        run_pair(2'b01, 2'b01, 1'b0, 32, "R3 high/high");
        run_pair(2'b01, 2'b10, 1'b0, 35, "R3 high/float");
        // R4
        run_pair(2'b11, 2'b00, 1'b0, 64, "R4 alias first");
        run_pair(2'b01, 2'b11, 1'b0, 35, "R4 alias second");
        run_pair(2'b11, 2'b11, 1'b0, 65, "R4 alias both");
        // R5
        run_pair(2'b01, 2'b01, 1'b1, 33, "R5 plus-one min");
        run_pair(2'b10, 2'b10, 1'b1, 66, "R5 plus-one max");
        // R8: mid-period change keeps the running period
        apply_reset(2'b01, 2'b01, 1'b0);
        repeat (10) @(negedge clk_ref);
        sel_a_i = 2'b10; sel_b_i = 2'b10; plus_one_i = 1'b1;
        wait_tick(n);
        check(n == 22, "R8 running period kept", n, 22);
        wait_tick(n);
        check(n == 66, "R8 new period", n, 66);
        // R8: change back just after a tick
        sel_a_i = 2'b00; sel_b_i = 2'b01; plus_one_i = 1'b0;
        wait_tick(n);
        check(n == 66, "R8 period in flight", n, 66);
        wait_tick(n);
        check(n == 33, "R8 next period", n, 33);
        // Random changes at arbitrary cycles, compared by the model
        apply_reset(2'b00, 2'b00, 1'b0);
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk_ref);
            if ($urandom_range(0, 19) == 0) begin
                sel_a_i    = 2'($urandom_range(0, 3));
                sel_b_i    = 2'($urandom_range(0, 3));
                plus_one_i = 1'($urandom_range(0, 1));
            end
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk_ref);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule